// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block sits beside the instruction fetch path and is looked up with the full fetch address in the same cycle the instruction is read. It answers three questions at once: whether the address holds a known branch, whether that branch is predicted taken, and where it goes. From these answers it produces the next fetch address. A hit on an entry whose taken bit is set steers fetch to the stored target with no bubble. Any other case steps to the sequential address.

A separate update port receives branches after they have been resolved further down the pipeline. Each update carries the branch address, the actual outcome and the actual target. If an entry already holds that address, the entry is refreshed in place. If no entry holds it, a new entry is created only when the branch was taken. Entries are registers searched in parallel, so the lookup is purely combinational and a same-cycle update becomes visible only from the next cycle on.

Replacement is driven by a two-state machine. In state FILL, invalid entries remain, and a new branch is placed into the lowest-numbered invalid entry. Transition FILL→FULL is taken when the last invalid entry is filled. In state FULL, every entry is valid, and a new branch evicts the entry under a round-robin pointer, which then advances (FULL→FULL). A synchronous reset takes either state back to FILL, clears all valid bits and zeroes the pointer.

Top module: `fetch_btb`

## Requirements
- R1: A fetch address that matches no valid entry gives lk_hit=0, lk_taken=0, lk_target=0 and next_pc = fetch_pc + 4.
- R2: A fetch address that matches a valid entry whose taken bit is 1 gives lk_hit=1, lk_taken=1 and next_pc = lk_target = the stored target, in the same cycle.
- R3: A fetch address that matches a valid entry whose taken bit is 0 gives lk_hit=1, lk_taken=0 and lk_target = the stored target, and next_pc = fetch_pc + 4.
- R4: An update with upd_taken=0 for an address that is not in the buffer creates no entry, so a later lookup of that address still misses.
- R5: An update with upd_taken=1 for an address that is not in the buffer creates an entry. From the next cycle, a lookup of that address hits with the new target and taken bit 1.
- R6: An update for an address already held overwrites the target and taken bit of that entry in place. It never creates a second entry, so no lookup matches more than one entry.
- R7: When every entry is valid, each new taken branch evicts an entry. Entries are evicted in the order they were first allocated, oldest first, and refreshes do not change this order.
- R8: When a lookup and an update name the same address in the same cycle, the lookup reports the contents held before the update.
- R9: A synchronous reset (rst=1 at a rising edge) invalidates every entry, so after reset every lookup misses.
- R10: Matching compares the full fetch address, so two addresses that differ only in their upper bits do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| lk_hit | output | 1 | Address is a known branch |
| lk_taken | output | 1 | Known branch is predicted taken (1 taken, 0 not taken) |
| lk_target | output | PC_W | Stored target of the matching entry, 0 on a miss |
| next_pc | output | PC_W | Next fetch address: the target when hit and taken, else fetch_pc + 4 |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 taken |
| upd_target | input | PC_W | Actual target of the resolved branch |

## Verification
The bench builds the buffer with ENTRIES=4 and PC_W=32. With only four entries, the FILL→FULL transition and several round-robin evictions are reached after a handful of updates. This makes the oldest-first eviction order, and its independence from refreshes, observable at the lookup port. The 32-bit width keeps the upper address bits in play, so pairs of addresses that differ only at bit 31 test full-address matching.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Replacement state: FILL while invalid entries remain, FULL afterwards.
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_FULL = 1'b1
    } fill_state_e;

    // What a presented update does to the storage this cycle.
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_REFRESH = 2'd1,
        ACT_PLACE   = 2'd2,
        ACT_EVICT   = 2'd3
    } upd_action_e;

endpackage

// File: rtl/btb_match.sv
module btb_match #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [PC_W-1:0]    key,
    input  logic [ENTRIES-1:0] valid_q,
    input  logic [PC_W-1:0]    tag_q [ENTRIES],
    output logic [ENTRIES-1:0] hit_vec,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx
);

    // One comparator per entry, all working in parallel.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == key);
    end

    assign hit = |hit_vec;

    // Encode the matching position; at most one bit is set.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_idx = hit_idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/btb_alloc.sv
module btb_alloc
    import btb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_valid,
    input  logic               upd_taken,
    input  logic               upd_hit,
    input  logic [IDX_W-1:0]   upd_idx,
    input  logic [ENTRIES-1:0] valid_q,
    output upd_action_e        action,
    output logic [IDX_W-1:0]   wr_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    fill_state_e      state_q, state_d;
    logic [IDX_W-1:0] rr_q, rr_d;
    logic [IDX_W-1:0] free_idx;
    logic             last_free;

    // Lowest-numbered invalid entry.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    // True when filling free_idx leaves no invalid entry.
    always_comb begin
        logic [ENTRIES-1:0] after;
        after = valid_q;
        after[free_idx] = 1'b1;
        last_free = &after;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            rr_q    <= '0;
        end else begin
            state_q <= state_d;
            rr_q    <= rr_d;
        end
    end

    // Next state and pointer.
    always_comb begin
        state_d = state_q;
        rr_d    = rr_q;
        unique case (state_q)
            ST_FILL: begin
                if (action == ACT_PLACE && last_free) begin
                    state_d = ST_FULL;
                end
            end
            ST_FULL: begin
                if (action == ACT_EVICT) begin
                    rr_d = (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    // Outputs: what to write, and where.
    always_comb begin
        action = ACT_NONE;
        wr_idx = '0;
        if (upd_valid) begin
            if (upd_hit) begin
                action = ACT_REFRESH;
                wr_idx = upd_idx;
            end else if (upd_taken) begin
                unique case (state_q)
                    ST_FILL: begin
                        action = ACT_PLACE;
                        wr_idx = free_idx;
                    end
                    ST_FULL: begin
                        action = ACT_EVICT;
                        wr_idx = rr_q;
                    end
                    default: action = ACT_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  upd_action_e        action,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PC_W-1:0]    wr_tag,
    input  logic [PC_W-1:0]    wr_target,
    input  logic               wr_taken,
    output logic [ENTRIES-1:0] valid_q,
    output logic [PC_W-1:0]    tag_q    [ENTRIES],
    output logic [PC_W-1:0]    target_q [ENTRIES],
    output logic [ENTRIES-1:0] taken_q
);

    logic do_write;
    assign do_write = (action != ACT_NONE);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic sel;
        assign sel = do_write && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
            end else if (sel) begin
                valid_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && !rst) begin
                tag_q[g]    <= wr_tag;
                target_q[g] <= wr_target;
                taken_q[g]  <= wr_taken;
            end
        end
    end

endmodule

// File: rtl/fetch_btb.sv
module fetch_btb
    import btb_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int PC_W      = 32,
    parameter int STEP      = 4,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_target,
    output logic [PC_W-1:0] next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] taken_q;
    logic [PC_W-1:0]    tag_q    [ENTRIES];
    logic [PC_W-1:0]    target_q [ENTRIES];

    logic [ENTRIES-1:0] lk_vec;
    logic [IDX_W-1:0]   lk_idx;
    logic [ENTRIES-1:0] upd_vec;
    logic               upd_hit;
    logic [IDX_W-1:0]   upd_idx;

    upd_action_e        action;
    logic [IDX_W-1:0]   wr_idx;

    // Fetch-side search against registered entries.
    btb_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_lk_match (
        .key     (fetch_pc),
        .valid_q (valid_q),
        .tag_q   (tag_q),
        .hit_vec (lk_vec),
        .hit     (lk_hit),
        .hit_idx (lk_idx)
    );

    // Update-side search, to refresh instead of duplicating.
    btb_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_upd_match (
        .key     (upd_pc),
        .valid_q (valid_q),
        .tag_q   (tag_q),
        .hit_vec (upd_vec),
        .hit     (upd_hit),
        .hit_idx (upd_idx)
    );

    btb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .upd_taken (upd_taken),
        .upd_hit   (upd_hit),
        .upd_idx   (upd_idx),
        .valid_q   (valid_q),
        .action    (action),
        .wr_idx    (wr_idx)
    );

    btb_store #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .action    (action),
        .wr_idx    (wr_idx),
        .wr_tag    (upd_pc),
        .wr_target (upd_target),
        .wr_taken  (upd_taken),
        .valid_q   (valid_q),
        .tag_q     (tag_q),
        .target_q  (target_q),
        .taken_q   (taken_q)
    );

    // Lookup answers and next fetch address.
    always_comb begin
        lk_taken  = 1'b0;
        lk_target = '0;
        if (lk_hit) begin
            lk_taken  = taken_q[lk_idx];
            lk_target = target_q[lk_idx];
        end
        next_pc = (lk_hit && lk_taken) ? lk_target : fetch_pc + PC_W'(STEP);
    end

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    parameter int STEP    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [PC_W-1:0]    fetch_pc,
    input logic               lk_hit,
    input logic               lk_taken,
    input logic [PC_W-1:0]    lk_target,
    input logic [PC_W-1:0]    next_pc,
    input logic               upd_valid,
    input logic [PC_W-1:0]    upd_pc,
    input logic               upd_taken,
    input logic [PC_W-1:0]    upd_target,
    input logic               upd_hit,
    input logic [ENTRIES-1:0] lk_vec
);

    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    assert_miss_seq_R1: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (next_pc == fetch_pc + PC_W'(STEP)) && !lk_taken);

    assert_taken_redirect_R2: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_taken) |-> (next_pc == lk_target));

    assert_nt_hit_seq_R3: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && !lk_taken) |-> (next_pc == fetch_pc + PC_W'(STEP)));

    assert_no_nt_alloc_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed) && !$past(rst) && $past(upd_valid && !upd_taken && !upd_hit)
         && fetch_pc == $past(upd_pc)) |-> !lk_hit);

    assert_taken_visible_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed) && !$past(rst) && $past(upd_valid && upd_taken)
         && fetch_pc == $past(upd_pc)) |-> (lk_hit && lk_taken && lk_target == $past(upd_target)));

    assert_single_match_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec));

    assert_reset_clears_R9: assert property (@(posedge clk)
        (armed && $past(rst) && !rst) |-> !lk_hit);

endmodule

bind fetch_btb btb_checker #(.ENTRIES(ENTRIES), .PC_W(PC_W), .STEP(STEP)) u_btb_checker (
    .clk        (clk),
    .rst        (rst),
    .fetch_pc   (fetch_pc),
    .lk_hit     (lk_hit),
    .lk_taken   (lk_taken),
    .lk_target  (lk_target),
    .next_pc    (next_pc),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .upd_target (upd_target),
    .upd_hit    (upd_hit),
    .lk_vec     (lk_vec)
);

// File: tb/fetch_btb_bench.sv
`timescale 1ns/1ps
module fetch_btb_bench;

    localparam int N  = 4;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] fetch_pc = '0;
    logic          lk_hit, lk_taken;
    logic [PW-1:0] lk_target, next_pc;
    logic          upd_valid = 1'b0;
    logic [PW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [PW-1:0] upd_target = '0;

    always #2.5 clk = ~clk;

    fetch_btb #(.ENTRIES(N), .PC_W(PW)) u_fetch_btb (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target), .next_pc(next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
    );

    typedef struct packed {
        logic [23:0]   req;
        logic [PW-1:0] pc;
        logic          hit;
        logic          taken;
        logic [PW-1:0] target;
        logic [PW-1:0] nxt;
    } exp_t;

    exp_t sb [$];
    int checks = 0;
    int failures = 0;

    // Reference: entries in allocation order (oldest at front).
    logic [PW-1:0] m_pc  [$];
    logic [PW-1:0] m_tgt [$];
    logic          m_tk  [$];

    task automatic model_find(input logic [PW-1:0] pc, output int pos);
        pos = -1;
        for (int i = 0; i < m_pc.size(); i++) if (m_pc[i] == pc) pos = i;
    endtask

    // One cycle: lookup of pc, optional resolved-branch update.
    task automatic cycle(input logic [23:0] req, input logic [PW-1:0] pc,
                         input logic uv, input logic [PW-1:0] upc,
                         input logic ut, input logic [PW-1:0] utgt);
        exp_t e;
        int pos;
        @(negedge clk);
        fetch_pc   = pc;
        upd_valid  = uv;
        upd_pc     = upc;
        upd_taken  = ut;
        upd_target = utgt;
        model_find(pc, pos);
        e.req = req;
        e.pc  = pc;
        if (pos >= 0) begin
            e.hit = 1'b1; e.taken = m_tk[pos]; e.target = m_tgt[pos];
        end else begin
            e.hit = 1'b0; e.taken = 1'b0; e.target = '0;
        end
        e.nxt = (e.hit && e.taken) ? e.target : pc + 32'd4;
        sb.push_back(e);
        if (uv) begin
            model_find(upc, pos);
            if (pos >= 0) begin
                m_tgt[pos] = utgt; m_tk[pos] = ut;
            end else if (ut) begin
                if (m_pc.size() == N) begin
                    void'(m_pc.pop_front()); void'(m_tgt.pop_front()); void'(m_tk.pop_front());
                end
                m_pc.push_back(upc); m_tgt.push_back(utgt); m_tk.push_back(1'b1);
            end
        end
    endtask

    task automatic look(input logic [23:0] req, input logic [PW-1:0] pc);
        cycle(req, pc, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; upd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc.delete(); m_tgt.delete(); m_tk.delete();
    endtask

    task automatic cmp(input logic [23:0] req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compares each cycle's outputs against the queued item.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.req, "hit", {31'd0, lk_hit}, {31'd0, e.hit});
                cmp(e.req, "taken", {31'd0, lk_taken}, {31'd0, e.taken});
                cmp(e.req, "target", lk_target, e.target);
                cmp(e.req, "next_pc", next_pc, e.nxt);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R1: misses after reset step sequentially
        look("R1", 32'h0000_0100);
        look("R1", 32'h8000_0100);
        // R4: not-taken miss allocates nothing
        cycle("R4", 32'h0000_0300, 1'b1, 32'h0000_0200, 1'b0, 32'h0000_0500);
        look("R4", 32'h0000_0200);
        // R8: same-cycle lookup sees the old (empty) contents
        cycle("R8", 32'h0000_0200, 1'b1, 32'h0000_0200, 1'b1, 32'h0000_0400);
        // R5 / R2: allocation visible next cycle, taken redirect
        look("R5", 32'h0000_0200);
        look("R2", 32'h0000_0200);
        // R10: upper-bit variant does not alias
        look("R10", 32'h8000_0200);
        // R6: refresh in place to not-taken; R8 lookup in the same cycle sees taken
        cycle("R8", 32'h0000_0200, 1'b1, 32'h0000_0200, 1'b0, 32'h0000_0404);
        look("R3", 32'h0000_0200);
        // Fill remaining entries (FILL to FULL)
        cycle("R5", 32'h0000_0210, 1'b1, 32'h0000_0210, 1'b1, 32'h0000_1210);
        cycle("R5", 32'h0000_0220, 1'b1, 32'h0000_0220, 1'b1, 32'h0000_1220);
        cycle("R10", 32'h8000_0230, 1'b1, 32'h0000_0230, 1'b1, 32'h0000_1230);
        // R6: all four distinct branches coexist, no duplicate slot used
        look("R6", 32'h0000_0200);
        look("R6", 32'h0000_0210);
        look("R6", 32'h0000_0220);
        look("R6", 32'h0000_0230);
        // R6: refresh of 0x210 while full must not evict anything
        cycle("R6", 32'h0000_0230, 1'b1, 32'h0000_0210, 1'b1, 32'h0000_2210);
        look("R6", 32'h0000_0200);
        look("R6", 32'h0000_0210);
        // R7: new branches evict oldest first
        cycle("R7", 32'h0000_0240, 1'b1, 32'h0000_0240, 1'b1, 32'h0000_1240);
        look("R7", 32'h0000_0200);
        look("R7", 32'h0000_0240);
        look("R7", 32'h0000_0210);
        cycle("R7", 32'h0000_0250, 1'b1, 32'h0000_0250, 1'b1, 32'h0000_1250);
        look("R7", 32'h0000_0210);
        look("R7", 32'h0000_0220);
        cycle("R7", 32'h0000_0260, 1'b1, 32'h0000_0260, 1'b1, 32'h0000_1260);
        look("R7", 32'h0000_0220);
        look("R7", 32'h0000_0230);
        look("R7", 32'h0000_0250);
        // R4 while full: not-taken miss evicts nothing
        cycle("R4", 32'h0000_0230, 1'b1, 32'h0000_0270, 1'b0, 32'h0000_1270);
        look("R4", 32'h0000_0270);
        look("R4", 32'h0000_0230);
        // R9: reset in mid-run clears everything
        @(negedge clk);
        #2;
        do_reset();
        look("R9", 32'h0000_0240);
        look("R9", 32'h0000_0260);
        // After reset, filling restarts cleanly
        cycle("R9", 32'h0000_0260, 1'b1, 32'h0000_0260, 1'b1, 32'h0000_3260);
        look("R2", 32'h0000_0260);
        @(negedge clk);
        upd_valid = 1'b0;
        repeat (3) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule